// File: doc/BRIEF.md
# Shared Control Strobe Generator with Per-Pin Handover

This block produces one control strobe for a parallel data port and fans it out to eight dedicated pins. Each pin can be switched between two owners. When its enable bit is set, the pin becomes an output and carries the shared strobe. When its enable bit is clear, the pin is an ordinary GPIO and follows its own direction and data-out bits.

Outside a transfer the strobe rests at a programmable idle level. During a transfer it emits one pulse per data word, signalled by a `beat` input. A pulse is the inverse of the idle level and lasts a programmable 1 to 15 clocks. After each pulse the line returns to the idle level for at least one clock. Beats that overlap a pulse are queued one deep, and a further overlapping beat sets a sticky overrun flag. A stop request never cuts a pulse short.

The generator is a four-state machine:
- **IDLE**: no transfer is running. The line shows the idle level, which follows the configuration.
- **WAIT**: a transfer is running and the line is at the idle level, waiting for a beat.
- **PULSE**: the line is inverted while the width counter runs down.
- **GAP**: one mandatory clock at the idle level.

The transitions are:
- IDLE→WAIT on start.
- WAIT→IDLE on stop.
- WAIT→PULSE on a beat.
- PULSE→GAP when the counter expires.
- GAP→IDLE on a stop, either live or held over.
- GAP→PULSE on a queued or live beat.
- GAP→WAIT otherwise.

Top module: `strobe_fanout`

## Requirements
- R1: Reset behaviour.
  - While reset is asserted, and in the first cycle after it, all enable bits are 0, the idle level is 0, the state is IDLE and `overrun` is 0.
  - Every pin therefore follows its GPIO bits (`pin_oe = gpio_dir`, `pin_out = gpio_dout`).
- R2: Enabled pins.
  - Configuration bits 11:4 are the pin enables, with bit 4+i controlling pin i. They are registered, so a change takes effect after the next clock edge.
  - An enabled pin has `pin_oe`=1 whatever its direction bit says, and carries the strobe.
- R3: Disabled pins. A pin whose enable is 0 drives `pin_oe = gpio_dir[i]` and `pin_out = gpio_dout[i]`, combinationally.
- R4: Idle level.
  - Configuration bit 0 is the idle level. In IDLE the strobe equals the value of bit 0 sampled at the previous clock edge.
  - From the edge that starts a transfer until the edge that returns to IDLE, the level stays at the value sampled on the start edge. Writes made during the transfer are applied once IDLE is re-entered.
- R5: Start.
  - `xfer_start` in IDLE enters WAIT and clears `overrun`.
  - `xfer_start` is ignored while a transfer is running.
  - `beat` is ignored in IDLE.
- R6: Pulse.
  - A beat sampled in WAIT produces a pulse starting in the next cycle. The pulse is the inverse of the idle level and lasts W cycles.
  - W is configuration bits 15:12, and a value of 0 is treated as 1.
- R7: Gap. Every pulse is followed by at least one cycle at the idle level (the GAP state) before another pulse may begin.
- R8: Beat queue.
  - A beat sampled during PULSE or GAP is queued, one deep. A queued beat starts the next pulse straight after the GAP cycle.
  - Two beats on consecutive cycles therefore give pulses separated by exactly one idle cycle.
- R9: Overrun.
  - A beat sampled during PULSE while a beat is already queued is dropped and sets `overrun`.
  - `overrun` stays set until the next accepted start.
- R10: Stop.
  - `xfer_stop` in WAIT returns to IDLE on that edge, and it wins over a simultaneous beat.
  - A stop during PULSE is held until the pulse and its GAP cycle complete, and any queued beat is then discarded.
  - The line never leaves PULSE directly for IDLE.
- R11: Handover. A pin with `gpio_dir`=1 and `gpio_dout` equal to the idle level shows no transition on `pin_out` or `pin_oe` when its enable is set while IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Configuration: [0] idle level, [11:4] pin enables, [15:12] pulse width |
| gpio_dout | input | 8 | GPIO data-out bits, one per pin |
| gpio_dir | input | 8 | GPIO direction bits, 1 = output |
| xfer_start | input | 1 | Start a transfer (one-cycle request) |
| xfer_stop | input | 1 | Request the end of the transfer |
| beat | input | 1 | One data word moved; requests a pulse |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| overrun | output | 1 | Sticky flag: a beat was lost |

## Verification
Results are due at different times after a stimulus:
- GPIO changes on disabled pins reach the pins in the same cycle.
- Enable changes, starts, stops and beats appear one edge later. A beat's pulse is visible in the cycle after the edge that samples it.
- A new idle level shows two edges after the stop that ends a transfer.

The bench drives inputs just after a falling edge and compares at the following falling edge. It checks against a cycle model that advances on each rising edge. Directed sequences count inverted cycles over a fixed window, so pulse widths, gaps, queueing and stop timing are checked as exact numbers.

// File: rtl/strb_pkg.sv
package strb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_GAP   = 2'd3
    } strb_state_e;
endpackage

// File: rtl/strb_gen.sv
module strb_gen
    import strb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_stop,
    input  logic             beat,
    input  logic             cfg_lvl,
    input  logic [CNT_W-1:0] cfg_width,
    output logic             strobe,
    output logic             overrun,
    output logic             lvl,
    output strb_state_e      state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    strb_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, load_w;
    logic             pend_q, pend_d;
    logic             stop_q, stop_d;
    logic             ovr_q, ovr_d;
    logic             lvl_q, lvl_d;

    assign load_w = (cfg_width == '0) ? ONE : cfg_width;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        stop_d  = stop_q;
        ovr_d   = ovr_q;
        lvl_d   = (state_q == ST_IDLE) ? cfg_lvl : lvl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start) begin
                    state_d = ST_WAIT;
                    ovr_d   = 1'b0;
                    pend_d  = 1'b0;
                    stop_d  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (xfer_stop) begin
                    state_d = ST_IDLE;
                end else if (beat) begin
                    state_d = ST_PULSE;
                    cnt_d   = load_w;
                end
            end
            ST_PULSE: begin
                if (xfer_stop) stop_d = 1'b1;
                if (beat) begin
                    if (pend_q) ovr_d  = 1'b1;
                    else        pend_d = 1'b1;
                end
                if (cnt_q == ONE) state_d = ST_GAP;
                else              cnt_d   = cnt_q - ONE;
            end
            ST_GAP: begin
                if (xfer_stop || stop_q) begin
                    state_d = ST_IDLE;
                    pend_d  = 1'b0;
                    stop_d  = 1'b0;
                end else if (pend_q || beat) begin
                    state_d = ST_PULSE;
                    cnt_d   = load_w;
                    pend_d  = pend_q && beat;
                end else begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            stop_q  <= 1'b0;
            ovr_q   <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
            stop_q  <= stop_d;
            ovr_q   <= ovr_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        strobe  = lvl_q ^ (state_q == ST_PULSE);
        overrun = ovr_q;
        lvl     = lvl_q;
        state   = state_q;
    end
endmodule

// File: rtl/strb_pinmux.sv
module strb_pinmux #(
    parameter int N_PINS = 8
) (
    input  logic              strobe,
    input  logic [N_PINS-1:0] en,
    input  logic [N_PINS-1:0] gpio_dout,
    input  logic [N_PINS-1:0] gpio_dir,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign pin_out[i] = en[i] ? strobe : gpio_dout[i];
        assign pin_oe[i]  = en[i] | gpio_dir[i];
    end
endmodule

// File: rtl/strobe_fanout.sv
module strobe_fanout
    import strb_pkg::*;
#(
    parameter int N_PINS  = 8,
    parameter int CFG_W   = 16,
    parameter int CNT_W   = 4,
    parameter int LVL_BIT = 0,
    parameter int EN_LSB  = 4,
    parameter int WID_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [N_PINS-1:0] gpio_dout,
    input  logic [N_PINS-1:0] gpio_dir,
    input  logic              xfer_start,
    input  logic              xfer_stop,
    input  logic              beat,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              overrun
);
    logic [N_PINS-1:0] en_q;
    logic              gen_strobe;
    logic              gen_lvl;
    strb_state_e       gen_state;
    logic              cfg_unused;

    assign cfg_unused = ^cfg_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= cfg_word[EN_LSB +: N_PINS];
    end

    strb_gen #(.CNT_W(CNT_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_stop  (xfer_stop),
        .beat       (beat),
        .cfg_lvl    (cfg_word[LVL_BIT]),
        .cfg_width  (cfg_word[WID_LSB +: CNT_W]),
        .strobe     (gen_strobe),
        .overrun    (overrun),
        .lvl        (gen_lvl),
        .state      (gen_state)
    );

    strb_pinmux #(.N_PINS(N_PINS)) u_mux (
        .strobe    (gen_strobe),
        .en        (en_q),
        .gpio_dout (gpio_dout),
        .gpio_dir  (gpio_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/strb_chk.sv
module strb_chk
    import strb_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input strb_state_e       state,
    input logic              lvl,
    input logic              strobe,
    input logic [N_PINS-1:0] en,
    input logic [N_PINS-1:0] pin_oe,
    input logic              cfg_lvl,
    input logic              xfer_start,
    input logic              overrun
);
    localparam int MAXW = (1 << CNT_W) - 1;

    logic          past_ok;
    logic [CNT_W:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_len <= '0;
        end else begin
            past_ok <= 1'b1;
            run_len <= (state == ST_PULSE) ? run_len + 1'b1 : '0;
        end
    end

    p_en_forces_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en & ~pin_oe) == '0);

    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == ST_IDLE && $past(state) == ST_IDLE) |-> strobe == $past(cfg_lvl));

    p_level_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(lvl));

    p_width_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (int'(run_len) < MAXW));

    p_gap_after_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state) == ST_PULSE && state != ST_PULSE) |-> state == ST_GAP);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(overrun) && !($past(state) == ST_IDLE && $past(xfer_start))) |-> overrun);

    p_stop_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == ST_IDLE && $past(state) != ST_IDLE) |-> ($past(state) == ST_WAIT || $past(state) == ST_GAP));
endmodule

bind strobe_fanout strb_chk #(.N_PINS(N_PINS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (gen_state),
    .lvl        (gen_lvl),
    .strobe     (gen_strobe),
    .en         (en_q),
    .pin_oe     (pin_oe),
    .cfg_lvl    (cfg_word[LVL_BIT]),
    .xfer_start (xfer_start),
    .overrun    (overrun)
);

// File: tb/strobe_fanout_test.sv
module strobe_fanout_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic [7:0]  gpio_dout = '0;
    logic [7:0]  gpio_dir = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_stop = 1'b0;
    logic        beat = 1'b0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic        overrun;

    always #5 clk = ~clk;

    strobe_fanout uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .gpio_dout(gpio_dout),
        .gpio_dir(gpio_dir), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .beat(beat), .pin_out(pin_out), .pin_oe(pin_oe), .overrun(overrun)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // reference model: 0 idle, 1 wait, 2 pulse, 3 gap
    int        m_state;
    int        m_cnt;
    bit        m_pend, m_stop, m_ovr, m_lvl;
    bit [7:0]  m_en;

    function automatic int width_of(logic [15:0] c);
        return (c[15:12] == 4'd0) ? 1 : int'(c[15:12]);
    endfunction

    function automatic logic [7:0] exp_out(bit [7:0] en, bit s, logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = en[i] ? s : d[i];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_pend <= 0; m_stop <= 0; m_ovr <= 0; m_lvl <= 0; m_en <= '0;
        end else begin
            m_en <= cfg_word[11:4];
            if (m_state == 0) m_lvl <= cfg_word[0];
            case (m_state)
                0: if (xfer_start) begin m_state <= 1; m_ovr <= 0; m_pend <= 0; m_stop <= 0; end
                1: if (xfer_stop) m_state <= 0;
                   else if (beat) begin m_state <= 2; m_cnt <= width_of(cfg_word); end
                2: begin
                    if (xfer_stop) m_stop <= 1;
                    if (beat) begin if (m_pend) m_ovr <= 1; else m_pend <= 1; end
                    if (m_cnt == 1) m_state <= 3; else m_cnt <= m_cnt - 1;
                end
                default: begin
                    if (xfer_stop || m_stop) begin m_state <= 0; m_pend <= 0; m_stop <= 0; end
                    else if (m_pend || beat) begin m_state <= 2; m_cnt <= width_of(cfg_word); m_pend <= m_pend && beat; end
                    else m_state <= 1;
                end
            endcase
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [7:0] eo;
        bit s;
        @(negedge clk);
        s  = m_lvl ^ (m_state == 2);
        eo = exp_out(m_en, s, gpio_dout);
        cmp("R2 R6 strobe on enabled pins", 32'(pin_out & m_en), 32'(eo & m_en));
        cmp("R3 gpio level on disabled pins", 32'(pin_out & ~m_en), 32'(eo & ~m_en));
        cmp("R2 R3 output enables", 32'(pin_oe), 32'(m_en | gpio_dir));
        cmp("R9 overrun flag", 32'(overrun), 32'(m_ovr));
    endtask

    task automatic pulse_in(ref logic sig);
        sig = 1'b1; tick(); sig = 1'b0;
    endtask

    task automatic count_high(int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            tick(); beat = 1'b0; xfer_stop = 1'b0;
            if (pin_out[0]) highs++;
        end
    endtask

    initial begin
        int h;
        int unsigned r;
        r = $urandom(32'd2024);
        gpio_dir = 8'h5A; gpio_dout = 8'h33;
        repeat (3) @(negedge clk);
        // R1: reset state seen at the pins
        cmp("R1 oe in reset", 32'(pin_oe), 32'h5A);
        cmp("R1 out in reset", 32'(pin_out), 32'h33);
        cmp("R1 overrun in reset", 32'(overrun), 32'h0);
        rst_n = 1'b1;
        tick();
        cmp("R1 oe after reset", 32'(pin_oe), 32'h5A);
        // R3: combinational GPIO path
        gpio_dout = 8'hC4; gpio_dir = 8'h0F; #1;
        cmp("R3 dout same cycle", 32'(pin_out), 32'hC4);
        cmp("R3 dir same cycle", 32'(pin_oe), 32'h0F);
        // R2: enable pins 4..7 with idle level 1, directions 0
        gpio_dir = 8'h00; cfg_word = 16'h0F01;
        tick(); tick();
        cmp("R2 forced oe", 32'(pin_oe), 32'hF0);
        cmp("R2 strobe idle level", 32'(pin_out[7:4]), 32'hF);
        // R11: handover with dout equal to idle level, dir=1
        cfg_word = 16'h0001; gpio_dout = 8'h01; gpio_dir = 8'h01; tick(); tick();
        cfg_word = 16'h0011;
        for (int k = 0; k < 3; k++) begin
            tick();
            cmp("R11 no transition on handover", 32'({pin_oe[0], pin_out[0]}), 32'h3);
        end
        // R6: width 3, idle 0, pin 0 enabled
        cfg_word = 16'h3010; tick(); tick();
        pulse_in(xfer_start);
        beat = 1'b1; count_high(10, h);
        cmp("R6 pulse width 3", 32'(h), 32'd3);
        // R6: width field 0 means 1
        cfg_word = 16'h0010;
        beat = 1'b1; count_high(6, h);
        cmp("R6 zero width as one", 32'(h), 32'd1);
        // R7 R8: two consecutive beats, width 2 -> 4 high cycles with one gap
        cfg_word = 16'h2010;
        beat = 1'b1; tick(); beat = 1'b1; count_high(10, h);
        cmp("R8 queued beat served", 32'(h + 1), 32'd4);
        // R9: three overlapping beats, width 4 -> overrun, two pulses
        cfg_word = 16'h4010;
        beat = 1'b1; tick(); beat = 1'b1; tick(); beat = 1'b1; count_high(14, h);
        cmp("R9 dropped beat", 32'(h + 2), 32'd8);
        cmp("R9 overrun set", 32'(overrun), 32'h1);
        // R5: start ignored mid-transfer, overrun stays
        pulse_in(xfer_start); tick();
        cmp("R5 start while active ignored", 32'(overrun), 32'h1);
        // R10: stop during a pulse of width 5
        cfg_word = 16'h5010;
        beat = 1'b1; tick(); xfer_stop = 1'b1; count_high(10, h);
        cmp("R10 pulse not cut", 32'(h + 1), 32'd5);
        // R5: beats in IDLE ignored
        beat = 1'b1; count_high(6, h); beat = 1'b0;
        cmp("R5 beat ignored in idle", 32'(h), 32'd0);
        // R5: start clears overrun
        pulse_in(xfer_start);
        cmp("R5 start clears overrun", 32'(overrun), 32'h0);
        // R10: stop and beat together in WAIT -> stop wins
        beat = 1'b1; xfer_stop = 1'b1; count_high(5, h);
        cmp("R10 stop beats beat", 32'(h), 32'd0);
        // R4: idle level held during transfer, applied after stop
        pulse_in(xfer_start);
        cfg_word = 16'h5011; tick();
        cmp("R4 level frozen in transfer", 32'(pin_out[0]), 32'h0);
        xfer_stop = 1'b1; tick(); xfer_stop = 1'b0;
        cmp("R4 level not yet applied", 32'(pin_out[0]), 32'h0);
        tick();
        cmp("R4 level applied in idle", 32'(pin_out[0]), 32'h1);
        // random phase
        for (int c = 0; c < 6000; c++) begin
            r = $urandom;
            beat       = (r[1:0] == 2'b00);
            xfer_start = (r[6:3] == 4'd0);
            xfer_stop  = (r[12:7] == 6'd0);
            if (r[17:13] == 5'd0) begin
                cfg_word = 16'($urandom);
                cfg_word[15:12] = 4'($urandom_range(0, 3));
            end
            if (r[21:18] == 4'd0) begin
                gpio_dout = 8'($urandom); gpio_dir = 8'($urandom);
            end
            tick();
        end
        beat = 1'b0; xfer_start = 1'b0; xfer_stop = 1'b0;
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule